// File: doc/BRIEF.md
# Fractional Line-Length Horizontal Counter

This block is the horizontal and line timebase for an image-sensor timing generator. It runs from a master clock and makes an internal pixel-clock enable at half that rate. It counts pixel clocks along each video line, restarts the count at a line length chosen by the active video mode, and counts lines within a frame. Drive-pulse decoders elsewhere in the chip compare their own positions against the count and line number that this block puts out.

Four modes come from two selects: the line standard (525 or 625 lines per frame) and the sampling format (component or composite).

- The component format has a whole number of pixel clocks per line.
- The 525-line composite format has an average line of 1137.5 pixel clocks. The block makes this by alternating lines of 1137 and 1138 clocks.
- The 625-line composite format has 1135-clock lines. Four lines in each 625-line frame are stretched by one clock, and these are spread evenly by a modulo accumulator.

Mode changes take effect only on a field latch strobe. A falling edge on the external horizontal sync restarts the line count. This keeps the block locked to an outside timing source.

Top module: `hline_timer`

## Requirements
- R1: `pix_ce_o` changes value on every master clock edge. The only exception is the edge on which a resync is applied, after which `pix_ce_o` is 0. The pixel count advances only on edges where `pix_ce_o` is 1.
- R2: `hcount_o` goes up by exactly one on each pixel-enabled edge until it reaches the active line length minus one. On the next enabled edge it returns to 0. It never exceeds the longest possible line length minus one.
- R3: The component format (`comp_i`=1) gives lines of 1144 pixel clocks with the 525-line standard (`std625_i`=0), and 1152 pixel clocks with the 625-line standard (`std625_i`=1).
- R4: The 525-line composite format gives lines that are each 1137 or 1138 pixel clocks long. Consecutive lines always differ, so every pair of consecutive lines totals 2275.
- R5: The 625-line composite format gives 1135-clock lines. Line k of a frame (k counted from 0) is stretched to 1136 when (4·k mod 625) + 4 ≥ 625, which is lines 156, 312, 468 and 624. The accumulator restarts at each frame start. With other parameter values, the rule uses the frame length N and the stretch count S in place of 625 and 4.
- R6: `line_start_o` is 1 exactly while `hcount_o` is 0. At a line start this lasts two master clocks, which is one pixel clock.
- R7: `vcount_o` goes up by one at each natural line end. It returns to 0 after line 524 (525-line standard) or line 624 (625-line standard). A resync leaves it unchanged.
- R8: The selects `std625_i` and `comp_i` are captured only on a clock edge where `field_latch_i` is 1. At all other times, changes on them have no effect on line length.
- R9: When `hsync_n_i` is sampled high and then low on two successive edges, `hcount_o` is 0 after the following edge. It stays 0 for two master clocks, reads 1 after that, and then runs a full line. Holding `hsync_n_i` low causes no further restarts.
- R10: In reset, `hcount_o`=0, `vcount_o`=0, `line_start_o`=1 and `pix_ce_o`=0. The active mode after reset is 525-line component.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| std625_i | input | 1 | Line standard select: 1 = 625 lines, 0 = 525 lines |
| comp_i | input | 1 | Format select: 1 = component, 0 = composite |
| field_latch_i | input | 1 | Per-field strobe that loads the two selects |
| hsync_n_i | input | 1 | External horizontal sync, active low |
| pix_ce_o | output | 1 | Pixel-clock enable, half the master rate |
| hcount_o | output | 11 | Pixel count within the line |
| line_start_o | output | 1 | High while the pixel count is zero |
| vcount_o | output | 10 | Line number within the frame |

## Verification
The assertions assume that `hsync_n_i` and the mode selects are synchronous to the master clock. They also assume that `field_latch_i` is a short strobe. The properties check only the cycle-level relations that follow: pixel enable toggling, count stepping and holding, line-number stepping, and mode stability between strobes. The stimulus drives every input on the falling clock edge and pulses the latch for one cycle. It drops sync only in the middle of a line, far from a natural wrap, so a restart and a line end never land together. The frame-level fractional pattern is checked on a second instance with short lines and frames, which shows the same spacing rule within the run length.

// File: rtl/hlt_pkg.sv
package hlt_pkg;

  typedef struct packed {
    logic is625;
    logic comp;
  } vmode_t;

  function automatic int line_len(vmode_t m, logic extra,
                                  int l525c, int l625c, int l525x, int l625x);
    int base;
    if (m.comp) base = m.is625 ? l625c : l525c;
    else        base = m.is625 ? l625x : l525x;
    return base + (extra ? 1 : 0);
  endfunction

  function automatic int max_len(int l525c, int l625c, int l525x, int l625x);
    int m;
    m = l525c;
    if (l625c > m)     m = l625c;
    if (l525x + 1 > m) m = l525x + 1;
    if (l625x + 1 > m) m = l625x + 1;
    return m;
  endfunction

  function automatic int frame_lines(vmode_t m, int n525, int n625);
    return m.is625 ? n625 : n525;
  endfunction

  function automatic logic acc_carry(int acc, int step, int modn);
    return (acc + step) >= modn;
  endfunction

  function automatic int acc_next(int acc, int step, int modn);
    return ((acc + step) >= modn) ? (acc + step - modn) : (acc + step);
  endfunction

endpackage

// File: rtl/hlt_pix_div.sv
module hlt_pix_div (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  output logic ce_o
);
  logic phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase_q <= 1'b0;
    else if (clear_i) phase_q <= 1'b0;
    else              phase_q <= ~phase_q;
  end

  assign ce_o = phase_q;
endmodule

// File: rtl/hlt_mode_reg.sv
module hlt_mode_reg
  import hlt_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load_i,
  input  logic   is625_i,
  input  logic   comp_i,
  output vmode_t mode_o
);
  vmode_t mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mode_q <= '{is625: 1'b0, comp: 1'b1};
    else if (load_i) mode_q <= '{is625: is625_i, comp: comp_i};
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/hlt_frac.sv
module hlt_frac
  import hlt_pkg::*;
#(
  parameter int AW   = 10,
  parameter int STEP = 4,
  parameter int MODN = 625
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   line_end_i,
  input  logic   frame_wrap_i,
  input  vmode_t mode_i,
  output logic   stretch_o
);
  logic          alt_q;
  logic [AW-1:0] acc_q;
  logic          cpst625, cpst525, carry;

  assign cpst625 =  mode_i.is625 & ~mode_i.comp;
  assign cpst525 = ~mode_i.is625 & ~mode_i.comp;
  assign carry   = acc_carry(int'(acc_q), STEP, MODN);

  assign stretch_o = (cpst625 & carry) | (cpst525 & alt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alt_q <= 1'b0;
      acc_q <= '0;
    end else if (line_end_i) begin
      alt_q <= ~alt_q;
      if (frame_wrap_i) acc_q <= '0;
      else if (cpst625) acc_q <= AW'(acc_next(int'(acc_q), STEP, MODN));
    end
  end
endmodule

// File: rtl/hlt_hcount.sv
module hlt_hcount #(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_i,
  input  logic          resync_i,
  input  logic [CW-1:0] len_i,
  output logic [CW-1:0] count_o,
  output logic          line_end_o
);
  logic [CW-1:0] count_q;

  assign line_end_o = ce_i & ~resync_i & (count_q >= (len_i - CW'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          count_q <= '0;
    else if (resync_i)   count_q <= '0;
    else if (line_end_o) count_q <= '0;
    else if (ce_i)       count_q <= count_q + CW'(1);
  end

  assign count_o = count_q;
endmodule

// File: rtl/hline_timer.sv
module hline_timer
  import hlt_pkg::*;
#(
  parameter int L525_COMP  = 1144,
  parameter int L625_COMP  = 1152,
  parameter int L525_CPST  = 1137,
  parameter int L625_CPST  = 1135,
  parameter int LINES_525  = 525,
  parameter int LINES_625  = 625,
  parameter int STRETCHES  = 4,
  localparam int MAXLEN    = max_len(L525_COMP, L625_COMP, L525_CPST, L625_CPST),
  localparam int CW        = $clog2(MAXLEN + 1),
  localparam int VW        = $clog2((LINES_625 > LINES_525) ? LINES_625 : LINES_525),
  localparam int AW        = $clog2(LINES_625)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          std625_i,
  input  logic          comp_i,
  input  logic          field_latch_i,
  input  logic          hsync_n_i,
  output logic          pix_ce_o,
  output logic [CW-1:0] hcount_o,
  output logic          line_start_o,
  output logic [VW-1:0] vcount_o
);
  // named internal events, observed by the bound checker
  logic          hs_q1, hs_q2;
  logic          resync;
  logic          pix_ce;
  logic          line_end;
  logic          frame_wrap;
  logic          stretch;
  vmode_t        act_mode;
  logic [CW-1:0] cur_len;
  logic [CW-1:0] hcount;
  logic [VW-1:0] vcount_q;
  logic [VW-1:0] frame_len;

  // sync edge detect from two registered samples
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q1 <= 1'b1;
      hs_q2 <= 1'b1;
    end else begin
      hs_q1 <= hsync_n_i;
      hs_q2 <= hs_q1;
    end
  end
  assign resync = hs_q2 & ~hs_q1;

  hlt_mode_reg u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (field_latch_i),
    .is625_i (std625_i),
    .comp_i  (comp_i),
    .mode_o  (act_mode)
  );

  hlt_pix_div u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (resync),
    .ce_o    (pix_ce)
  );

  hlt_frac #(.AW(AW), .STEP(STRETCHES), .MODN(LINES_625)) u_frac (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_end_i   (line_end),
    .frame_wrap_i (frame_wrap),
    .mode_i       (act_mode),
    .stretch_o    (stretch)
  );

  assign cur_len = CW'(line_len(act_mode, stretch,
                                L525_COMP, L625_COMP, L525_CPST, L625_CPST));

  hlt_hcount #(.CW(CW)) u_hcnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_i       (pix_ce),
    .resync_i   (resync),
    .len_i      (cur_len),
    .count_o    (hcount),
    .line_end_o (line_end)
  );

  assign frame_len  = VW'(frame_lines(act_mode, LINES_525, LINES_625));
  assign frame_wrap = line_end & (vcount_q >= (frame_len - VW'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          vcount_q <= '0;
    else if (frame_wrap) vcount_q <= '0;
    else if (line_end)   vcount_q <= vcount_q + VW'(1);
  end

  assign pix_ce_o     = pix_ce;
  assign hcount_o     = hcount;
  assign line_start_o = (hcount == '0);
  assign vcount_o     = vcount_q;
endmodule

// File: rtl/hlt_chk.sv
module hlt_chk #(
  parameter int CW     = 11,
  parameter int VW     = 10,
  parameter int MAXLEN = 1152
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pix_ce,
  input logic [CW-1:0] hcount,
  input logic          line_start,
  input logic [VW-1:0] vcount,
  input logic          resync,
  input logic          line_end,
  input logic          field_latch,
  input logic [1:0]    act_mode
);
  // R1
  ce_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !resync |=> (pix_ce != $past(pix_ce)));

  // R9
  resync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> (!pix_ce && hcount == '0));

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_ce && !line_end && !resync) |=> (hcount == $past(hcount) + CW'(1)));

  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_ce && !resync) |=> $stable(hcount));

  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hcount < CW'(MAXLEN));

  // R6
  start_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_start) |=> line_start);

  // R7
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> $stable(vcount));

  // R7
  line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> (vcount == $past(vcount) + VW'(1) || vcount == '0));

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !field_latch |=> $stable(act_mode));
endmodule

bind hline_timer hlt_chk #(.CW(CW), .VW(VW), .MAXLEN(MAXLEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pix_ce      (pix_ce),
  .hcount      (hcount),
  .line_start  (line_start_o),
  .vcount      (vcount_q),
  .resync      (resync),
  .line_end    (line_end),
  .field_latch (field_latch_i),
  .act_mode    (act_mode)
);

// File: tb/sim_hline_timer.sv
module sim_hline_timer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // instance u0: default parameters
  logic s0_625 = 1'b0, s0_comp = 1'b1, s0_lat = 1'b0, s0_hs_n = 1'b1;
  logic ce0, ls0;
  logic [10:0] hc0;
  logic [9:0]  vc0;

  // instance u1: short lines and frames for frame-level checks
  logic s1_625 = 1'b0, s1_comp = 1'b1, s1_lat = 1'b0, s1_hs_n = 1'b1;
  logic ce1, ls1;
  logic [4:0] hc1;
  logic [3:0] vc1;

  hline_timer u0 (
    .clk(clk), .rst_n(rst_n), .std625_i(s0_625), .comp_i(s0_comp),
    .field_latch_i(s0_lat), .hsync_n_i(s0_hs_n),
    .pix_ce_o(ce0), .hcount_o(hc0), .line_start_o(ls0), .vcount_o(vc0)
  );

  hline_timer #(
    .L525_COMP(20), .L625_COMP(24), .L525_CPST(17), .L625_CPST(15),
    .LINES_525(7), .LINES_625(9), .STRETCHES(4)
  ) u1 (
    .clk(clk), .rst_n(rst_n), .std625_i(s1_625), .comp_i(s1_comp),
    .field_latch_i(s1_lat), .hsync_n_i(s1_hs_n),
    .pix_ce_o(ce1), .hcount_o(hc1), .line_start_o(ls1), .vcount_o(vc1)
  );

  int nchk = 0, nfail = 0;
  bit done = 0;

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // line monitors: master cycles between line-start rises
  int cyc0, dlen0, dvc0, vcs0, rises0; logic prev0;
  int cyc1, dlen1, dvc1, vcs1, rises1; logic prev1;

  always @(negedge clk) begin
    if (!rst_n) begin
      cyc0 = 0; prev0 = 1'b0; rises0 = 0; vcs0 = 0;
      cyc1 = 0; prev1 = 1'b0; rises1 = 0; vcs1 = 0;
    end else begin
      cyc0++;
      if (ls0 && !prev0) begin
        dlen0 = cyc0; dvc0 = vcs0; vcs0 = int'(vc0); cyc0 = 0; rises0++;
      end
      prev0 = ls0;
      cyc1++;
      if (ls1 && !prev1) begin
        dlen1 = cyc1; dvc1 = vcs1; vcs1 = int'(vc1); cyc1 = 0; rises1++;
      end
      prev1 = ls1;
    end
  end

  task automatic next_line0(output int len, output int vc);
    int n = rises0;
    do @(posedge clk); while (rises0 == n);
    len = dlen0 / 2;
    vc  = dvc0;
  endtask

  task automatic next_line1(output int len, output int vc);
    int n = rises1;
    do @(posedge clk); while (rises1 == n);
    len = dlen1 / 2;
    vc  = dvc1;
  endtask

  task automatic latch0(logic is625, logic comp);
    @(negedge clk); s0_625 = is625; s0_comp = comp; s0_lat = 1'b1;
    @(negedge clk); s0_lat = 1'b0;
  endtask

  task automatic latch1(logic is625, logic comp);
    @(negedge clk); s1_625 = is625; s1_comp = comp; s1_lat = 1'b1;
    @(negedge clk); s1_lat = 1'b0;
  endtask

  task automatic t_reset;
    logic prev;
    @(negedge clk);
    chk("R10 hcount in reset", int'(hc0), 0);
    chk("R10 vcount in reset", int'(vc0), 0);
    chk("R10 line_start in reset", int'(ls0), 1);
    chk("R10 pix_ce in reset", int'(ce0), 0);
    rst_n = 1'b1;
    prev = ce0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R1 pix_ce toggles", int'(ce0), int'(!prev));
      prev = ce0;
    end
  endtask

  task automatic t_start_width;
    int len, vc;
    next_line0(len, vc);
    @(negedge clk);
    chk("R6 start still high", int'(ls0), 1);
    chk("R6 count zero", int'(hc0), 0);
    @(negedge clk);
    chk("R6 start low after one pixel", int'(ls0), 0);
    chk("R2 count one", int'(hc0), 1);
  endtask

  task automatic t_latch_ignore;
    int len, vc;
    @(negedge clk); s0_625 = 1'b1; s0_comp = 1'b1;
    next_line0(len, vc);
    for (int i = 0; i < 2; i++) begin
      next_line0(len, vc);
      chk("R8 selects ignored without strobe", len, 1144);
      chk("R3 525 component length", len, 1144);
    end
  endtask

  task automatic t_625_comp;
    int len, vc;
    latch0(1'b1, 1'b1);
    next_line0(len, vc);
    for (int i = 0; i < 2; i++) begin
      next_line0(len, vc);
      chk("R3 625 component length", len, 1152);
    end
  endtask

  task automatic t_525_cpst;
    int len, vc;
    int l[4];
    latch0(1'b0, 1'b0);
    next_line0(len, vc);
    for (int i = 0; i < 4; i++) next_line0(l[i], vc);
    for (int i = 0; i < 4; i++)
      chk("R4 line is 1137 or 1138", int'(l[i] == 1137 || l[i] == 1138), 1);
    for (int i = 0; i < 3; i++)
      chk("R4 pair sums to 2275", l[i] + l[i+1], 2275);
  endtask

  task automatic t_625_cpst;
    int len, vc, pvc;
    latch0(1'b1, 1'b0);
    next_line0(len, pvc);
    for (int i = 0; i < 3; i++) begin
      next_line0(len, vc);
      chk("R5 625 composite base length", len, 1135);
      chk("R7 line number steps", vc, pvc + 1);
      pvc = vc;
    end
  endtask

  task automatic t_resync;
    int len, vc, vb;
    next_line0(len, vc);
    repeat (300) @(negedge clk);
    s0_hs_n = 1'b0;
    vb = int'(vc0);
    @(negedge clk);
    @(negedge clk);
    chk("R9 count cleared", int'(hc0), 0);
    chk("R9 line_start on resync", int'(ls0), 1);
    chk("R9 pix_ce cleared", int'(ce0), 0);
    @(negedge clk);
    chk("R9 count held zero", int'(hc0), 0);
    chk("R9 pix_ce resumes", int'(ce0), 1);
    @(negedge clk);
    chk("R9 count leaves zero", int'(hc0), 1);
    chk("R7 resync keeps line number", int'(vc0), vb);
    next_line0(len, vc);
    chk("R9 full line after resync", len, 1135);
    chk("R7 resynced line number", vc, vb);
    chk("R7 next line number", int'(vc0), vb + 1);
    s0_hs_n = 1'b1;
  endtask

  task automatic t_frame_small;
    int len, vc, acc, exp_len, guard;
    guard = 0;
    do begin next_line1(len, vc); guard++; end while (vc1 != 0 && guard < 30);
    for (int k = 0; k < 7; k++) begin
      next_line1(len, vc);
      chk("R7 small 525 line index", vc, k);
      chk("R3 small 525 component length", len, 20);
    end
    chk("R7 wrap after last 525 line", int'(vc1), 0);
    latch1(1'b1, 1'b0);
    guard = 0;
    do begin next_line1(len, vc); guard++; end while (vc1 != 0 && guard < 30);
    acc = 0;
    for (int k = 0; k < 9; k++) begin
      exp_len = 15 + ((acc + 4 >= 9) ? 1 : 0);
      acc = (acc + 4) % 9;
      next_line1(len, vc);
      chk("R5 stretched-line pattern", len, exp_len);
      chk("R7 small 625 line index", vc, k);
    end
    chk("R7 wrap after last 625 line", int'(vc1), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_start_width();
    t_latch_ignore();
    t_625_comp();
    t_525_cpst();
    t_625_cpst();
    t_resync();
    t_frame_small();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule